// File: doc/BRIEF.md
# Capture timer with handshake-cleared status flags

This block is a free-running up-counter with four input-capture channels and a status word. On each clock the counter advances by one. When a capture pin rises, the block passes the edge through a two-stage synchroniser and copies the running count into that channel's capture register. It also raises the channel's status flag. When the counter wraps from all-ones to zero, it raises an overflow flag. Software reaches the counter, the status word and the four capture registers over a small synchronous register bus.

Status flags are sticky and need a two-step handshake to clear. Software must first read the status word while a flag is 1, which arms that flag. A later write of 0 to that bit then clears it. A write of 0 to a bit that has not been armed leaves the flag set, and a write of 1 never has an effect. Each flag arms and clears on its own. The flags are provided only as levels on the status word.

Top module: `capture_timer`

## Requirements
- R1: After reset, the status flags and all four capture registers read 0, and the counter starts from 0.
- R2: The counter rises by exactly 1 on every clock. A bus write to the counter (address 0) replaces that step: the written value is visible after the next clock edge and counting continues from it.
- R3: When the counter steps from 0xFFFFFFFF to 0, status bit 4 (overflow) becomes 1. This includes the case where 0xFFFFFFFF was just loaded by a bus write.
- R4: Capture pin `cap_in[i]` maps to channels A, B, C and D for i = 0, 1, 2, 3. A rising edge is recognised after two synchronising flip-flops. On the third clock edge after the pin rises, the capture register takes the count that was visible between the second and third edges, and status bit i becomes 1. A pin held high does not capture again.
- R5: A capture register keeps its value until the next capture on its own channel. A new capture overwrites it even while the channel flag is still 1, and the flag stays 1.
- R6: In the status word (address 1), bits 0 to 3 are the capture flags for A to D and bit 4 is overflow. Bits 31 to 5 read 0 and ignore writes.
- R7: Writing 1 to a flag bit has no effect. Writing 0 to a flag that has not been read as 1 since it was last set also has no effect.
- R8: A read strobe on the status word while a flag is 1 arms that flag. A later status write with 0 in that bit clears it. Flags that are not armed, or that are written with 1, are untouched by the same write.
- R9: If a flag's setting event and a valid clearing write land on the same clock edge, the flag stays 1 and loses its armed state. A fresh read is needed before a 0 write can clear it.
- R10: Addresses map as follows: 0 is the counter, 1 is the status word, and 2 to 5 are the capture registers A to D. Capture registers are also writable by the bus. Read data is a combinational function of the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_in | input | 4 | Asynchronous capture pins, bit i is channel A+i |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flags on a status read) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |

## Verification
Two functions can meet on one edge: a flag's setting event and a software clearing write to that same flag. The bench arms the overflow flag by reading it. It then loads 0xFFFFFFFF into the counter and issues the clearing write in the next cycle, so the wrap and the clear hit the same edge. It checks that the flag survives that edge. It then checks that a further 0 write without a new read still leaves the flag at 1, and that a read followed by a 0 write finally clears it.

// File: rtl/capture_timer.sv
module capture_timer #(
  parameter int CNT_W  = 32,
  parameter int NUM_CAP = 4,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CAP-1:0] cap_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [CNT_W-1:0]   bus_wdata,
  output logic [CNT_W-1:0]   bus_rdata
);
  localparam int NFLAG   = NUM_CAP + 1;
  localparam int OVF_BIT = NUM_CAP;
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam int CAP_BASE = 2;

  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cap_q [NUM_CAP];
  logic [NUM_CAP-1:0] sync1, sync2, prev;
  logic [NFLAG-1:0]   flags, armed, set_ev, clr_hit;
  logic               cnt_wr, st_wr, st_rd, ovf_ev;
  logic [NUM_CAP-1:0] rise;

  assign cnt_wr  = bus_wr && (bus_addr == A_CNT);
  assign st_wr   = bus_wr && (bus_addr == A_STAT);
  assign st_rd   = bus_rd && (bus_addr == A_STAT);
  assign ovf_ev  = !cnt_wr && (cnt == '1);
  assign rise    = sync2 & ~prev;
  assign set_ev  = {ovf_ev, rise};
  assign clr_hit = {NFLAG{st_wr}} & ~bus_wdata[NFLAG-1:0] & armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      cnt   <= cnt_wr ? bus_wdata : cnt + CNT_W'(1);
      sync1 <= cap_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  for (genvar i = 0; i < NUM_CAP; i++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst)
        cap_q[i] <= '0;
      else if (rise[i])
        cap_q[i] <= cnt;
      else if (bus_wr && bus_addr == ADDR_W'(CAP_BASE + i))
        cap_q[i] <= bus_wdata;
    end

    // R4
    capture_load_chk: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> flags[i] && cap_q[i] == $past(cnt));
  end

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[f] <= 1'b0;
        armed[f] <= 1'b0;
      end else if (set_ev[f]) begin
        flags[f] <= 1'b1;
        armed[f] <= 1'b0;
      end else if (clr_hit[f]) begin
        flags[f] <= 1'b0;
        armed[f] <= 1'b0;
      end else if (st_rd && flags[f]) begin
        armed[f] <= 1'b1;
      end
    end

    // R7
    unarmed_hold_chk: assert property (@(posedge clk) disable iff (rst)
      flags[f] && !armed[f] |=> flags[f]);

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
      set_ev[f] && st_wr && !bus_wdata[f] |=> flags[f] && !armed[f]);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CNT)  bus_rdata = cnt;
    if (bus_addr == A_STAT) bus_rdata = {{(CNT_W-NFLAG){1'b0}}, flags};
    for (int i = 0; i < NUM_CAP; i++)
      if (bus_addr == ADDR_W'(CAP_BASE + i)) bus_rdata = cap_q[i];
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> cnt == $past(cnt) + CNT_W'(1));

  // R3
  wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cnt == '1 && !cnt_wr |=> flags[OVF_BIT] && cnt == '0);
endmodule

// File: tb/tb_capture_timer.sv
`timescale 1ns/1ps
module tb_capture_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cap_in = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  capture_timer dut (
    .clk(clk), .rst(rst), .cap_in(cap_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // op: 0 capture pulse (data = pin mask), 1 write, 2 read strobe and compare
  localparam int NV = 17;
  localparam logic [68:0] VEC [NV] = '{
    {2'd2, 3'd1, 32'h0,        32'h0},  // R1 status clear
    {2'd0, 3'd0, 32'h1,        32'h0},  // R4 capture A
    {2'd1, 3'd1, 32'h0,        32'h0},  // R7 zero without read
    {2'd2, 3'd1, 32'h0,        32'h1},  // R7 still set, arms A
    {2'd1, 3'd1, 32'hFFFFFFFF, 32'h0},  // R7 ones do nothing
    {2'd2, 3'd1, 32'h0,        32'h1},
    {2'd1, 3'd1, 32'h0,        32'h0},  // R8 clear armed A
    {2'd2, 3'd1, 32'h0,        32'h0},
    {2'd0, 3'd0, 32'hA,        32'h0},  // R4 capture B and D
    {2'd2, 3'd1, 32'h0,        32'hA},  // arms B, D
    {2'd0, 3'd0, 32'h4,        32'h0},  // capture C, unarmed
    {2'd1, 3'd1, 32'h0,        32'h0},  // R8 clears B, D only
    {2'd2, 3'd1, 32'h0,        32'h4},  // arms C
    {2'd1, 3'd1, 32'hFFFFFFE4, 32'h0},  // R6 upper bits ignored, C kept by 1
    {2'd2, 3'd1, 32'h0,        32'h4},
    {2'd1, 3'd1, 32'h0,        32'h0},
    {2'd2, 3'd1, 32'h0,        32'h0}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    #1 check(bus_rdata, exp, tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic cap_pulse(input logic [3:0] m);
    cap_in = m;
    idle(3);
    cap_in = '0;
    idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, v2, c;
    idle(3);
    rst = 1'b0;
    // R1 reset state
    peek(3'd1, v); check(v, 32'h0, "R1 status after reset");
    for (int i = 0; i < 4; i++) begin
      peek(3'(2 + i), v); check(v, 32'h0, "R1 capture reg after reset");
    end
    peek(3'd0, v); check({31'h0, v < 32'd8}, 32'h1, "R1 counter starts near 0");

    for (int k = 0; k < NV; k++) begin
      case (VEC[k][68:67])
        2'd0: cap_pulse(VEC[k][35:32]);
        2'd1: do_write(VEC[k][66:64], VEC[k][63:32]);
        default: do_read(VEC[k][66:64], VEC[k][31:0], $sformatf("R6/R7/R8 table vec %0d", k));
      endcase
    end

    // R2 counting and load
    peek(3'd0, v); idle(1); peek(3'd0, v2);
    check(v2, v + 32'd1, "R2 step by one");
    do_write(3'd0, 32'h0000_1234);
    peek(3'd0, v); check(v, 32'h0000_1234, "R2 load value");
    idle(1); peek(3'd0, v); check(v, 32'h0000_1235, "R2 count after load");

    // R4 / R5 capture on channel C
    cap_in[2] = 1'b1;
    idle(2); peek(3'd0, v);
    idle(1);
    peek(3'd4, c); check(c, v, "R4 captured count C");
    peek(3'd1, c); check(c, 32'h4, "R4 flag C set");
    idle(3);
    peek(3'd4, c); check(c, v, "R4 held pin no recapture");
    cap_in[2] = 1'b0;
    idle(3);
    cap_in[2] = 1'b1;
    idle(2); peek(3'd0, v2);
    idle(1);
    peek(3'd4, c); check(c, v2, "R5 overwrite while flag set");
    peek(3'd1, c); check(c, 32'h4, "R5 flag stays set");
    cap_in[2] = 1'b0;
    do_read(3'd1, 32'h4, "R8 arm C");
    do_write(3'd1, 32'h0);
    peek(3'd1, c); check(c, 32'h0, "R8 C cleared");

    // R10 capture register written by bus
    do_write(3'd2, 32'hCAFE_0001);
    peek(3'd2, c); check(c, 32'hCAFE_0001, "R10 capture A written");

    // R3 wrap sets overflow
    do_write(3'd0, 32'hFFFF_FFFE);
    peek(3'd1, c); check(c, 32'h0, "R3 no flag before wrap");
    idle(1);
    peek(3'd1, c); check(c, 32'h0, "R3 no flag at all-ones");
    idle(1);
    peek(3'd1, c); check(c, 32'h10, "R3 overflow flag bit4");
    peek(3'd0, c); check(c, 32'h0, "R3 counter wrapped");

    // R9 set and clear on the same edge
    do_read(3'd1, 32'h10, "R9 arm overflow");
    do_write(3'd0, 32'hFFFF_FFFF);
    do_write(3'd1, 32'h0);
    peek(3'd1, c); check(c, 32'h10, "R9 set wins over clear");
    do_write(3'd1, 32'h0);
    peek(3'd1, c); check(c, 32'h10, "R9 arm lost, write ignored");
    do_read(3'd1, 32'h10, "R9 re-arm");
    do_write(3'd1, 32'h0);
    peek(3'd1, c); check(c, 32'h0, "R8 overflow cleared after re-arm");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule